// File: doc/BRIEF.md
# Page Write Collector

This block gathers the data bytes of one write transaction into a page-sized holding buffer. It then hands them to the storage array as one timed programming cycle. A protocol engine gives it a start address at the beginning of the transaction and a stream of data bytes. At the Stop condition it sends a commit strobe. The block keeps a per-entry written mask, so only the bytes that were actually received are written. Array locations in the page that received no byte keep their old contents.

Inside the page only the low offset bits of the address advance, and they wrap at the page edge. A transaction longer than one page therefore overwrites its own earlier bytes. The page part of the address never changes during a transaction. After a commit, the block stays busy for a parameterised number of clocks. While busy it takes no bytes, no address loads and no commits. It also reports the address of the last byte written plus one, wrapped inside the page, so the engine can reload its address counter.

Byte input is a valid/ready stream. A byte is taken on a clock edge where `byte_valid` and `byte_ready` are both high. `byte_ready` is low for the whole programming cycle and high otherwise. A source may hold `byte_valid` high while `byte_ready` is low; the byte is simply not taken until ready returns. The address load, the commit, the busy flag and the array write port are plain control pins.

Top module: `page_commit_buf`

## Requirements
- R1: After reset, `busy` is 0, `byte_ready` is 1, `arr_we` is 0 and `next_addr` is 0.
- R2: `addr_load` while idle loads `load_addr` as the current address, and `next_addr` shows it on the next cycle. A byte taken in the same cycle is stored at the offset of `load_addr`, and `next_addr` then shows that address plus one.
- R3: Each byte that is taken is stored at the current in-page offset (the low log2(PAGE_BYTES) address bits), and that offset then advances by one. The upper page bits stay unchanged until the next load.
- R4: An offset advance from PAGE_BYTES-1 wraps to offset 0 of the same page.
- R5: When more than PAGE_BYTES bytes are taken before a commit, later bytes replace earlier ones at the wrapped offsets, and only the last value at each offset is written.
- R6: A commit while idle with at least one buffered byte raises `arr_we` for exactly one clock, the cycle after the commit. In that cycle `arr_page` is the transaction page, and byte lane k of `arr_wdata` (bits 8k+7..8k) holds the byte buffered for offset k.
- R7: Bit k of `arr_be` is 1 during the write exactly when a byte was taken for offset k since the last programming cycle. All other lanes are disabled, so those array bytes keep their contents.
- R8: `busy` goes high the cycle after an accepted commit and stays high for exactly PROG_CYCLES clocks. Throughout, `byte_ready` is 0, and `addr_load` and `commit` have no effect.
- R9: When the programming cycle ends, the written mask is cleared. A later commit with no new bytes causes no write, and a later write enables only the newly taken offsets.
- R10: A commit with no buffered bytes causes no array write and does not raise `busy`.
- R11: A single taken byte followed by a commit gives one write with exactly one `arr_be` bit set.
- R12: A byte taken in the same cycle as the commit is part of that programming cycle.
- R13: `next_addr` equals the address of the last byte taken plus one, with in-page wrap, and holds that value through the programming cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Load the start address of a transaction |
| load_addr | input | ADDR_W | Start address to load |
| byte_valid | input | 1 | A data byte is offered |
| byte_ready | output | 1 | The block can take a byte (idle) |
| byte_data | input | DATA_W | Offered data byte |
| commit | input | 1 | Stop seen: start the programming cycle |
| busy | output | 1 | Programming cycle in progress |
| arr_we | output | 1 | Array page write strobe, one clock |
| arr_page | output | ADDR_W-log2(PAGE_BYTES) | Page number being written |
| arr_be | output | PAGE_BYTES | Per-byte write enables |
| arr_wdata | output | PAGE_BYTES*DATA_W | Page data, lane k for offset k |
| next_addr | output | ADDR_W | Last written address plus one, wrapped in page |

## Verification
The hardest case to reach from the ports is input arriving during the programming window. Loads, commits and offered bytes must all leave no trace, and the mask must then be empty. The stimulus commits a page and, while `busy` is high, holds `byte_valid`, `addr_load` and `commit` asserted for half the window. Once idle, the bench checks that `next_addr` has not moved and that a bare commit produces no array write. Wrap and overwrite are reached by starting near the page end and streaming more than a page of bytes. The commit-with-byte case is reached by raising `commit` on the same edge as the last byte.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_HOLD  = 2'd2
  } pcb_phase_e;
endpackage

// File: rtl/pcb_addr_ctr.sv
module pcb_addr_ctr #(
  parameter int ADDR_W = 13,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [OFF_W-1:0]  eff_off,
  output logic [ADDR_W-OFF_W-1:0] page,
  output logic [OFF_W-1:0]  off
);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam logic [OFF_W-1:0] OFF_MAX = '1;

  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  load_off;

  assign load_off = load_addr[OFF_W-1:0];
  assign eff_off  = load ? load_off : off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
    end else begin
      if (load) page_q <= load_addr[ADDR_W-1:OFF_W];
      if (step) off_q <= eff_off + OFF_W'(1);
      else if (load) off_q <= load_off;
    end
  end

  assign page = page_q;
  assign off  = off_q;

  // R4: offset wraps inside the page
  p_offset_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && off_q == OFF_MAX) |=> (off_q == '0));
  // R3: page bits only move on a load
  p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(page_q));
endmodule

// File: rtl/pcb_page_buf.sv
module pcb_page_buf #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [OFF_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    clr_mask,
  output logic [DEPTH-1:0]        mask,
  output logic [DEPTH-1:0]        mask_nxt,
  output logic [DEPTH*DATA_W-1:0] data_flat
);
  logic [DEPTH-1:0] mask_q;
  logic [DEPTH-1:0] hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic [DATA_W-1:0] data_q;
    assign hit[i] = wr_en && (wr_idx == OFF_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q    <= '0;
        mask_q[i] <= 1'b0;
      end else begin
        if (hit[i]) data_q <= wr_data;
        if (clr_mask) mask_q[i] <= 1'b0;
        else if (hit[i]) mask_q[i] <= 1'b1;
      end
    end

    assign data_flat[i*DATA_W +: DATA_W] = data_q;
  end

  assign mask     = mask_q;
  assign mask_nxt = mask_q | hit;

  // R5: a written entry is marked in the mask
  p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_mask) |=> mask_q[$past(wr_idx)]);
  // R9: clearing empties the mask
  p_mask_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_mask |=> (mask_q == '0));
endmodule

// File: rtl/pcb_prog_timer.sv
module pcb_prog_timer
  import pcb_pkg::*;
#(
  parameter int PROG_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic wr_pulse,
  output logic done
);
  localparam int CNT_W = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;

  pcb_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (go) begin
          phase_q <= PH_WRITE;
          cnt_q   <= CNT_W'(PROG_CYCLES - 1);
        end
        PH_WRITE, PH_HOLD: begin
          if (cnt_q == '0) phase_q <= PH_IDLE;
          else begin
            phase_q <= PH_HOLD;
            cnt_q   <= cnt_q - CNT_W'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy     = (phase_q != PH_IDLE);
  assign wr_pulse = (phase_q == PH_WRITE);
  assign done     = busy && (cnt_q == '0);

  // checker: length of the busy window
  logic [31:0] chk_len;
  always_ff @(posedge clk) begin
    if (!rst_n) chk_len <= '0;
    else if (busy) chk_len <= chk_len + 32'd1;
    else chk_len <= '0;
  end

  // R8: busy lasts exactly PROG_CYCLES clocks
  p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (chk_len == 32'(PROG_CYCLES)));
  // R6: the write pulse opens the busy window
  p_pulse_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_pulse);
endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 5000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         addr_load,
  input  logic [ADDR_W-1:0]            load_addr,
  input  logic                         byte_valid,
  output logic                         byte_ready,
  input  logic [DATA_W-1:0]            byte_data,
  input  logic                         commit,
  output logic                         busy,
  output logic                         arr_we,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] arr_page,
  output logic [PAGE_BYTES-1:0]        arr_be,
  output logic [PAGE_BYTES*DATA_W-1:0] arr_wdata,
  output logic [ADDR_W-1:0]            next_addr
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic                  idle, take, ld, go;
  logic                  wr_pulse, done;
  logic [OFF_W-1:0]      eff_off, off;
  logic [PAGE_W-1:0]     page;
  logic [PAGE_BYTES-1:0] mask, mask_nxt;

  assign idle = !busy;
  assign take = byte_valid && idle;
  assign ld   = addr_load && idle;
  assign go   = commit && idle && (|mask_nxt);

  pcb_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_addr(load_addr),
    .step(take), .eff_off(eff_off), .page(page), .off(off)
  );

  pcb_page_buf #(.DEPTH(PAGE_BYTES), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(take), .wr_idx(eff_off),
    .wr_data(byte_data), .clr_mask(done), .mask(mask),
    .mask_nxt(mask_nxt), .data_flat(arr_wdata)
  );

  pcb_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy),
    .wr_pulse(wr_pulse), .done(done)
  );

  assign byte_ready = idle;
  assign arr_we     = wr_pulse;
  assign arr_be     = wr_pulse ? mask : '0;
  assign arr_page   = page;
  assign next_addr  = {page, off};

  // R10: a write always carries at least one enabled lane
  p_we_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_be != '0));
  // R13: the reported address holds while programming
  p_addr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(next_addr));
  // R8: buffered state is frozen during the programming window
  p_mask_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(mask));
endmodule

// File: tb/page_commit_buf_test.sv
module page_commit_buf_test;
  localparam int AW = 13;
  localparam int PB = 32;
  localparam int PC = 20;
  localparam int PW = AW - 5;

  logic clk = 0, rst_n = 0;
  logic addr_load = 0, byte_valid = 0, commit = 0;
  logic [AW-1:0] load_addr = '0;
  logic [7:0] byte_data = '0;
  logic byte_ready, busy, arr_we;
  logic [PW-1:0] arr_page;
  logic [PB-1:0] arr_be;
  logic [PB*8-1:0] arr_wdata;
  logic [AW-1:0] next_addr;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  page_commit_buf #(.ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(PB), .PROG_CYCLES(PC)) uut (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .load_addr(load_addr),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .commit(commit), .busy(busy), .arr_we(arr_we), .arr_page(arr_page),
    .arr_be(arr_be), .arr_wdata(arr_wdata), .next_addr(next_addr)
  );

  // bench model
  logic [PW-1:0]   m_page = '0;
  logic [4:0]      m_off = '0;
  logic [PB-1:0]   m_mask = '0;
  logic [PB*8-1:0] m_data = '0;

  logic [PB-1:0]   q_be[$];
  logic [PW-1:0]   q_page[$];
  logic [PB*8-1:0] q_data[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [PB*8-1:0] act, input logic [PB*8-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [PB*8-1:0] lane_mask(input logic [PB-1:0] be);
    logic [PB*8-1:0] m = '0;
    for (int k = 0; k < PB; k++) if (be[k]) m[k*8 +: 8] = 8'hFF;
    return m;
  endfunction

  // monitor: compare each array write against the scoreboard
  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      if (q_be.size() == 0) begin
        check(0, "R10", "unexpected array write", arr_be, '0);
      end else begin
        logic [PB-1:0] eb;
        logic [PW-1:0] ep;
        logic [PB*8-1:0] ed, lm;
        eb = q_be.pop_front(); ep = q_page.pop_front(); ed = q_data.pop_front();
        lm = lane_mask(eb);
        check(arr_be == eb, "R7", "write enables", arr_be, eb);
        check(arr_page == ep, "R6", "write page", arr_page, ep);
        check((arr_wdata & lm) == (ed & lm), "R6", "write data", arr_wdata & lm, ed & lm);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic model_byte(input logic [7:0] b);
    m_data[m_off*8 +: 8] = b;
    m_mask[m_off] = 1'b1;
    m_off = m_off + 5'd1;
  endtask

  task automatic load_send(input logic [AW-1:0] a, input logic [7:0] b);
    addr_load = 1; load_addr = a; byte_valid = 1; byte_data = b;
    m_page = a[AW-1:5]; m_off = a[4:0];
    model_byte(b);
    tick();
    addr_load = 0; byte_valid = 0;
  endtask

  task automatic send(input logic [7:0] b);
    byte_valid = 1; byte_data = b;
    model_byte(b);
    tick();
    byte_valid = 0;
  endtask

  task automatic push_expect();
    if (m_mask != '0) begin
      q_be.push_back(m_mask); q_page.push_back(m_page); q_data.push_back(m_data);
    end
    m_mask = '0;
  endtask

  task automatic do_commit();
    commit = 1;
    push_expect();
    tick();
    commit = 0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!busy) break;
      n++;
    end
    check(n == PC, req, "busy length", n, PC);
  endtask

  task automatic check_addr(input string req);
    logic [AW-1:0] e;
    e = {m_page, m_off};
    @(negedge clk);
    check(next_addr == e, req, "next_addr", next_addr, e);
  endtask

  initial begin
    #400000;
    check(0, "R8", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1", "busy after reset", busy, 0);
    check(byte_ready == 1, "R1", "ready after reset", byte_ready, 1);
    check(arr_we == 0, "R1", "we after reset", arr_we, 0);
    check(next_addr == 0, "R1", "next_addr after reset", next_addr, 0);
    @(posedge clk); #1;

    // R2 R11 single byte with load in same cycle
    load_send(13'h0123, 8'h5A);
    check_addr("R2");
    do_commit();
    wait_idle("R8");
    check_addr("R13");
    check(q_be.size() == 0, "R11", "single write consumed", q_be.size(), 0);

    // R3 R4 wrap near page end
    load_send(13'h0A5C, 8'h10);
    for (int i = 1; i < 6; i++) send(8'h10 + 8'(i));
    check_addr("R4");
    do_commit();
    wait_idle("R8");
    check_addr("R3");

    // R5 overwrite: 40 bytes from offset 5
    load_send(13'h1E45, 8'h80);
    for (int i = 1; i < 40; i++) send(8'h80 + 8'(i));
    check_addr("R5");
    do_commit();
    wait_idle("R8");

    // R10 empty commit: no write, no busy
    commit = 1; tick(); commit = 0;
    @(negedge clk);
    check(busy == 0, "R10", "busy after empty commit", busy, 0);
    @(posedge clk); #1;

    // R8 R9 stuffing while busy
    load_send(13'h0300, 8'hC1);
    send(8'hC2);
    do_commit();
    byte_valid = 1; byte_data = 8'hEE; addr_load = 1; load_addr = 13'h1FFF; commit = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(byte_ready == 0, "R8", "ready while busy", byte_ready, 0);
    end
    byte_valid = 0; addr_load = 0; commit = 0;
    begin
      int n = 10;
      for (int i = 0; i < 1000; i++) begin
        @(negedge clk);
        if (!busy) break;
        n++;
      end
      check(n == PC, "R8", "busy length with stuffing", n, PC);
    end
    check(next_addr == {m_page, m_off}, "R8", "address untouched by busy input",
          next_addr, {m_page, m_off});
    @(posedge clk); #1;
    commit = 1; tick(); commit = 0;
    @(negedge clk);
    check(busy == 0, "R9", "mask cleared: bare commit idle", busy, 0);
    @(posedge clk); #1;

    // R12 byte and commit in the same cycle; R7 sparse lanes
    load_send(13'h0447, 8'h31);
    byte_valid = 1; byte_data = 8'h32; commit = 1;
    model_byte(8'h32);
    push_expect();
    tick();
    byte_valid = 0; commit = 0;
    wait_idle("R12");
    check_addr("R13");

    repeat (4) @(negedge clk);
    check(q_be.size() == 0, "R6", "all expected writes seen", q_be.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule